// File: doc/BRIEF.md
# Register DMA Kickoff and Path Reset Sequencer

This block launches a command buffer that has already been prepared in memory, and it resets a control path of the register DMA engine. A kickoff request names a control path, one of two queues, the direction (read or write), a last-command marker, a read source for reads, the buffer base address and the buffer length in 32-bit words. The block checks the request. If the request passes, the block packs a 32-bit command descriptor and sends four register writes, one after another, over a simple request/acknowledge bus: one to the engine mode register, two to the path's queue register pair, and one to the trigger register in that path's own control space.

A reset request names only a path. The block enables the engine, writes the path's reset register, and then polls that register. It waits a programmable number of cycles before each read. It stops when a read returns zero or after a bounded number of reads. A request that fails its checks produces a one-cycle reject pulse and no bus traffic.

Top module: `regdma_kick_ctrl`

## Requirements
- R1: The descriptor word holds the read source in bits 31:30, but only for a read (these bits are zero for a write). Bit 24 holds the last-command flag. Bits 23:22 hold the operation code: 2 for a read, 1 for a write. Bits 13:0 hold the buffer length in words. All other bits are zero.
- R2: An accepted kickoff performs exactly four writes, in this order: value 1 to engine offset 0x004; the buffer address to the path's queue register; the descriptor to the queue register plus 4; and the trigger word.
- R3: The queue register of path p sits at engine offset 0x014 + 16·p. Every access carries the request's path index on `bus_path`.
- R4: The trigger write goes to offset 0x0D4 with `bus_ctl_space` = 1. Its data is 0x1 for queue 0 and 0x10 for queue 1. Every engine access has `bus_ctl_space` = 0.
- R5: A request is rejected in any of these cases: the address is not a multiple of 256; the word count is 0 or above 16383; or the path index is not below NUM_PATHS. The reject signal is a one-cycle pulse one cycle after the start. A rejected request produces no bus access and busy stays low.
- R6: A write kickoff is rejected unless both completion flags (`done_blk_sel`, `done_reg_wr`) are 1. A read kickoff is rejected when `read_src` ≥ 4, and for a read the completion flags have no effect.
- R7: A reset writes 1 to offset 0x004, then writes 1 to offset 0x0E4 + 4·p, then reads that same offset. The first read request appears WAIT_CYC+1 cycles after the acknowledge of the previous access, and every later read follows the same rule. Polling stops after a read that returns zero, or after MAX_POLLS reads.
- R8: `busy` rises on the clock edge that accepts a start. It falls on the clock edge after the acknowledge of the sequence's final access.
- R9: Only one access is outstanding at a time. `bus_req` and the address and data stay unchanged until `bus_ack`. Start requests that arrive while busy are ignored and do not cause a reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_kick | input | 1 | Start a kickoff with the request fields (takes priority over start_reset) |
| start_reset | input | 1 | Start a reset of path `path_idx` |
| path_idx | input | PATH_W | Control path index |
| queue_sel | input | 1 | Queue select: 0 or 1 |
| op_read | input | 1 | 1 = read operation, 0 = write operation |
| last_flag | input | 1 | Last-command marker for the descriptor |
| read_src | input | 3 | Read source index, valid range 0 to 3 |
| buf_addr | input | 32 | Buffer base address |
| buf_dwords | input | 16 | Buffer length in 32-bit words |
| done_blk_sel | input | 1 | The buffer holds a block-select command |
| done_reg_wr | input | 1 | The buffer holds a register-write command |
| busy | output | 1 | A sequence is running |
| reject | output | 1 | One-cycle pulse for a rejected request |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_ctl_space | output | 1 | 1 = access in the path control space, 0 = engine space |
| bus_path | output | PATH_W | Path index of the current sequence |
| bus_addr | output | ADDR_W | Byte offset of the access |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
Kickoffs are tried in both directions, on the lowest and the highest path, on both queues, with the last flag set and clear, and with word counts of 1 and 16383. This separates swapped descriptor fields, a read source that leaks into write descriptors, a wrong stride and a wrong trigger word. Each rejection rule is tried alone next to an otherwise legal request, so a check that is too loose or too strict shows up on its own. Resets are run with a status that clears on the first read and with one that never clears, which separates early exit from the poll limit and measures the wait gap. An acknowledge latency that varies, and a start pulse sent in the middle of a sequence, exercise the hold and ignore behaviour.

// File: rtl/regdma_pkg.sv
package regdma_pkg;

    localparam int DESC_W       = 32;
    localparam int DW_CNT_W     = 14;
    localparam int DW_CNT_MAX   = (1 << DW_CNT_W) - 1;
    localparam int ALIGN_BITS   = 8;
    localparam int MODE_OFF     = 'h004;
    localparam int QUEUE_BASE   = 'h014;
    localparam int QUEUE_STRIDE = 16;
    localparam int TRIG_OFF     = 'h0D4;
    localparam int RST_BASE     = 'h0E4;
    localparam int RST_STRIDE   = 4;
    localparam int NUM_SRC      = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MODE,
        ST_QADDR,
        ST_QDESC,
        ST_TRIG,
        ST_RSTW,
        ST_WAIT,
        ST_POLL
    } seq_state_e;

    typedef struct packed {
        logic                rd;
        logic                last;
        logic                queue;
        logic [1:0]          src;
        logic [31:0]         addr;
        logic [DW_CNT_W-1:0] dwords;
    } kick_req_t;

    function automatic logic [DESC_W-1:0] build_desc(input kick_req_t r);
        logic [DESC_W-1:0] d;
        d = '0;
        d[31:30] = r.rd ? r.src : 2'b00;
        d[24]    = r.last;
        d[23:22] = r.rd ? 2'd2 : 2'd1;
        d[DW_CNT_W-1:0] = r.dwords;
        return d;
    endfunction

    function automatic logic [31:0] trig_word(input logic q);
        return q ? 32'h0000_0010 : 32'h0000_0001;
    endfunction

endpackage

// File: rtl/regdma_validate.sv
module regdma_validate #(
    parameter int NUM_PATHS = 6,
    parameter int PATH_W    = 3
) (
    input  logic [PATH_W-1:0] path_idx,
    input  logic              is_reset,
    input  logic              op_read,
    input  logic [2:0]        read_src,
    input  logic [31:0]       buf_addr,
    input  logic [15:0]       buf_dwords,
    input  logic              done_blk_sel,
    input  logic              done_reg_wr,
    output logic              ok
);
    import regdma_pkg::*;

    logic path_ok, addr_ok, len_ok, dir_ok;

    always_comb begin
        path_ok = 32'(path_idx) < NUM_PATHS;
        addr_ok = buf_addr[ALIGN_BITS-1:0] == '0;
        len_ok  = (buf_dwords != '0) && (32'(buf_dwords) <= DW_CNT_MAX);
        dir_ok  = op_read ? (32'(read_src) < NUM_SRC)
                          : (done_blk_sel && done_reg_wr);
        ok      = is_reset ? path_ok : (path_ok && addr_ok && len_ok && dir_ok);
    end

endmodule

// File: rtl/regdma_wait_timer.sv
module regdma_wait_timer #(
    parameter int WAIT_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(WAIT_CYC - 1);
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = cnt == '0;

    p_timer_bound_r7: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < WAIT_CYC);

endmodule

// File: rtl/regdma_seq.sv
module regdma_seq #(
    parameter int PATH_W    = 3,
    parameter int ADDR_W    = 12,
    parameter int MAX_POLLS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go_kick,
    input  logic                  go_reset,
    input  regdma_pkg::kick_req_t req_in,
    input  logic [PATH_W-1:0]     path_in,
    input  logic                  timer_expired,
    output logic                  timer_load,
    output logic                  timer_run,
    output logic                  busy,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic                  bus_ctl_space,
    output logic [PATH_W-1:0]     bus_path,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [31:0]           bus_wdata,
    input  logic                  bus_ack,
    input  logic [31:0]           bus_rdata
);
    import regdma_pkg::*;

    localparam int PC_W = $clog2(MAX_POLLS + 1);

    seq_state_e          state;
    kick_req_t           req_q;
    logic [PATH_W-1:0]   path_q;
    logic                is_rst_q;
    logic [PC_W-1:0]     polls;
    logic                acked;
    logic [ADDR_W-1:0]   q_reg_addr, rst_reg_addr;

    assign acked = bus_req && bus_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_q    <= '0;
            path_q   <= '0;
            is_rst_q <= 1'b0;
            polls    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (go_kick || go_reset) begin
                    state    <= ST_MODE;
                    req_q    <= req_in;
                    path_q   <= path_in;
                    is_rst_q <= !go_kick;
                    polls    <= '0;
                end
                ST_MODE:  if (acked) state <= is_rst_q ? ST_RSTW : ST_QADDR;
                ST_QADDR: if (acked) state <= ST_QDESC;
                ST_QDESC: if (acked) state <= ST_TRIG;
                ST_TRIG:  if (acked) state <= ST_IDLE;
                ST_RSTW:  if (acked) state <= ST_WAIT;
                ST_WAIT:  if (timer_expired) state <= ST_POLL;
                ST_POLL: if (acked) begin
                    if (bus_rdata == '0 || 32'(polls) == MAX_POLLS - 1)
                        state <= ST_IDLE;
                    else begin
                        polls <= polls + 1'b1;
                        state <= ST_WAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign timer_load = acked && (state == ST_RSTW || state == ST_POLL);
    assign timer_run  = state == ST_WAIT;

    assign q_reg_addr   = ADDR_W'(QUEUE_BASE) + ADDR_W'(32'(path_q) * QUEUE_STRIDE);
    assign rst_reg_addr = ADDR_W'(RST_BASE) + ADDR_W'(32'(path_q) * RST_STRIDE);

    always_comb begin
        bus_req       = 1'b1;
        bus_we        = 1'b1;
        bus_ctl_space = 1'b0;
        bus_addr      = '0;
        bus_wdata     = '0;
        case (state)
            ST_MODE: begin
                bus_addr  = ADDR_W'(MODE_OFF);
                bus_wdata = 32'd1;
            end
            ST_QADDR: begin
                bus_addr  = q_reg_addr;
                bus_wdata = req_q.addr;
            end
            ST_QDESC: begin
                bus_addr  = q_reg_addr + ADDR_W'(4);
                bus_wdata = build_desc(req_q);
            end
            ST_TRIG: begin
                bus_ctl_space = 1'b1;
                bus_addr      = ADDR_W'(TRIG_OFF);
                bus_wdata     = trig_word(req_q.queue);
            end
            ST_RSTW: begin
                bus_addr  = rst_reg_addr;
                bus_wdata = 32'd1;
            end
            ST_POLL: begin
                bus_we   = 1'b0;
                bus_addr = rst_reg_addr;
            end
            default: begin
                bus_req = 1'b0;
                bus_we  = 1'b0;
            end
        endcase
    end

    assign busy     = state != ST_IDLE;
    assign bus_path = path_q;

    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata)
                                   && $stable(bus_we) && $stable(bus_ctl_space)));

    p_trig_word_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ctl_space) |-> ($onehot(bus_wdata) && (bus_wdata[0] || bus_wdata[4])));

    p_desc_fields_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_QDESC) |-> (bus_wdata[13:0] != '0 && bus_wdata[21:14] == '0
                                 && bus_wdata[29:25] == '0 && bus_wdata[23:22] != 2'd0
                                 && bus_wdata[23:22] != 2'd3));

    p_poll_limit_r7: assert property (@(posedge clk) disable iff (rst)
        32'(polls) < MAX_POLLS);

    p_wait_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |=> (state == ST_WAIT || state == ST_POLL));

    p_path_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(bus_path));

endmodule

// File: rtl/regdma_kick_ctrl.sv
module regdma_kick_ctrl #(
    parameter int NUM_PATHS = 6,
    parameter int ADDR_W    = 12,
    parameter int WAIT_CYC  = 100000,
    parameter int MAX_POLLS = 2,
    localparam int PATH_W   = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) + 1 : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_kick,
    input  logic              start_reset,
    input  logic [PATH_W-1:0] path_idx,
    input  logic              queue_sel,
    input  logic              op_read,
    input  logic              last_flag,
    input  logic [2:0]        read_src,
    input  logic [31:0]       buf_addr,
    input  logic [15:0]       buf_dwords,
    input  logic              done_blk_sel,
    input  logic              done_reg_wr,
    output logic              busy,
    output logic              reject,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_ctl_space,
    output logic [PATH_W-1:0] bus_path,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);
    import regdma_pkg::*;

    logic      req_ok, start_any, go_kick, go_reset;
    logic      t_load, t_run, t_exp;
    kick_req_t req_pack;

    regdma_validate #(.NUM_PATHS(NUM_PATHS), .PATH_W(PATH_W)) u_check (
        .path_idx     (path_idx),
        .is_reset     (!start_kick),
        .op_read      (op_read),
        .read_src     (read_src),
        .buf_addr     (buf_addr),
        .buf_dwords   (buf_dwords),
        .done_blk_sel (done_blk_sel),
        .done_reg_wr  (done_reg_wr),
        .ok           (req_ok)
    );

    assign start_any = (start_kick || start_reset) && !busy;
    assign go_kick   = start_any && start_kick && req_ok;
    assign go_reset  = start_any && !start_kick && req_ok;

    always_comb begin
        req_pack.rd     = op_read;
        req_pack.last   = last_flag;
        req_pack.queue  = queue_sel;
        req_pack.src    = read_src[1:0];
        req_pack.addr   = buf_addr;
        req_pack.dwords = buf_dwords[DW_CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) reject <= 1'b0;
        else     reject <= start_any && !req_ok;
    end

    regdma_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (t_load),
        .run     (t_run),
        .expired (t_exp)
    );

    regdma_seq #(.PATH_W(PATH_W), .ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .go_kick       (go_kick),
        .go_reset      (go_reset),
        .req_in        (req_pack),
        .path_in       (path_idx),
        .timer_expired (t_exp),
        .timer_load    (t_load),
        .timer_run     (t_run),
        .busy          (busy),
        .bus_req       (bus_req),
        .bus_we        (bus_we),
        .bus_ctl_space (bus_ctl_space),
        .bus_path      (bus_path),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_ack       (bus_ack),
        .bus_rdata     (bus_rdata)
    );

    p_reject_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        reject |-> (!busy && !bus_req));

    p_reject_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        reject |=> !reject || $past(start_kick || start_reset));

endmodule

// File: tb/regdma_kick_ctrl_test.sv
module regdma_kick_ctrl_test;
    localparam int NP   = 6;
    localparam int PW   = 4;
    localparam int WAIT = 20;

    logic clk = 0, rst = 1;
    logic start_kick = 0, start_reset = 0, queue_sel = 0, op_read = 0, last_flag = 0;
    logic [PW-1:0] path_idx = '0;
    logic [2:0]    read_src = '0;
    logic [31:0]   buf_addr = '0;
    logic [15:0]   buf_dwords = '0;
    logic done_blk_sel = 0, done_reg_wr = 0;
    logic busy, reject, bus_req, bus_we, bus_ctl_space;
    logic [PW-1:0] bus_path;
    logic [11:0]   bus_addr;
    logic [31:0]   bus_wdata;
    logic bus_ack = 0;
    logic [31:0] bus_rdata = '0;

    regdma_kick_ctrl #(.NUM_PATHS(NP), .ADDR_W(12), .WAIT_CYC(WAIT), .MAX_POLLS(2)) uut (
        .clk(clk), .rst(rst), .start_kick(start_kick), .start_reset(start_reset),
        .path_idx(path_idx), .queue_sel(queue_sel), .op_read(op_read), .last_flag(last_flag),
        .read_src(read_src), .buf_addr(buf_addr), .buf_dwords(buf_dwords),
        .done_blk_sel(done_blk_sel), .done_reg_wr(done_reg_wr), .busy(busy), .reject(reject),
        .bus_req(bus_req), .bus_we(bus_we), .bus_ctl_space(bus_ctl_space), .bus_path(bus_path),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // expected access: {we, space, path, addr, data}
    typedef logic [1+1+PW+12+32-1:0] acc_t;
    acc_t exp_q[$];
    string tag_q[$];
    logic [31:0] poll_q[$];
    bit exp_busy = 0, clr_pend = 0, in_req = 0, gap_chk = 0;
    int ncnt = 0, wcnt = 0, lat = 1, last_ack = 0;

    function automatic logic [31:0] ref_desc(bit rd, bit last, int src, int dw);
        logic [31:0] d;
        d = rd ? (32'(src) << 30) : 32'd0;
        d = d | (32'(last) << 24) | ((rd ? 32'd2 : 32'd1) << 22) | 32'(dw);
        return d;
    endfunction

    task automatic push(bit we, bit sp, int p, int a, logic [31:0] d, string t);
        exp_q.push_back({we, sp, PW'(p), 12'(a), d});
        tag_q.push_back(t);
    endtask

    // reference model of the bus side, evaluated every cycle
    always @(negedge clk) begin
        ncnt++;
        if (clr_pend) begin exp_busy = 0; clr_pend = 0; end
        if (!rst) chk(busy === exp_busy, "R8 busy", 64'(busy), 64'(exp_busy));
        if (bus_ack) begin
            bus_ack = 0;
        end else if (bus_req) begin
            if (!in_req) begin
                in_req = 1; wcnt = 0;
                if (!bus_we && gap_chk)
                    chk(ncnt - last_ack == WAIT + 1, "R7 wait gap", 64'(ncnt - last_ack), 64'(WAIT + 1));
            end
            if (wcnt >= lat) begin
                acc_t got, e;
                string t;
                got = {bus_we, bus_ctl_space, bus_path, bus_addr, bus_we ? bus_wdata : 32'd0};
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected access", 64'(got), 64'd0);
                end else begin
                    e = exp_q.pop_front(); t = tag_q.pop_front();
                    chk(got === e, t, 64'(got), 64'(e));
                    if (exp_q.size() == 0) clr_pend = 1;
                end
                bus_rdata = (!bus_we && poll_q.size() > 0) ? poll_q.pop_front() : 32'd0;
                bus_ack = 1; in_req = 0; last_ack = ncnt;
            end else wcnt++;
        end
    end

    task automatic set_req(int p, bit q, bit rd, bit last, int src, logic [31:0] a, int dw, bit fs, bit fw);
        path_idx = PW'(p); queue_sel = q; op_read = rd; last_flag = last;
        read_src = 3'(src); buf_addr = a; buf_dwords = 16'(dw); done_blk_sel = fs; done_reg_wr = fw;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && (exp_busy || clr_pend); i++) @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R2 all accesses seen", 64'(exp_q.size()), 64'd0);
        gap_chk = 0;
    endtask

    task automatic kick_ok(int p, bit q, bit rd, bit last, int src, logic [31:0] a, int dw, bit fs, bit fw);
        int qa;
        qa = 'h14 + 16 * p;
        @(negedge clk);
        set_req(p, q, rd, last, src, a, dw, fs, fw);
        push(1, 0, p, 'h004, 32'd1, "R2 mode write");
        push(1, 0, p, qa, a, "R3 queue address");
        push(1, 0, p, qa + 4, ref_desc(rd, last, src, dw), "R1 descriptor");
        push(1, 1, p, 'h0D4, q ? 32'h10 : 32'h1, "R4 trigger");
        start_kick = 1;
        @(posedge clk); #1 start_kick = 0; exp_busy = 1;
        chk(reject === 1'b0, "R5 no reject on legal", 64'(reject), 0);
    endtask

    task automatic try_bad(int p, bit rd, int src, logic [31:0] a, int dw, bit fs, bit fw, bit is_rst, string t);
        @(negedge clk);
        set_req(p, 0, rd, 0, src, a, dw, fs, fw);
        if (is_rst) start_reset = 1; else start_kick = 1;
        @(posedge clk); #1 start_kick = 0; start_reset = 0;
        chk(reject === 1'b1, t, 64'(reject), 1);
        chk(busy === 1'b0, t, 64'(busy), 0);
        @(posedge clk); #1;
        chk(reject === 1'b0, "R5 reject one cycle", 64'(reject), 0);
        repeat (3) @(negedge clk);
        chk(bus_req === 1'b0, t, 64'(bus_req), 0);
    endtask

    task automatic reset_path(int p, logic [31:0] s1, logic [31:0] s2);
        @(negedge clk);
        path_idx = PW'(p);
        push(1, 0, p, 'h004, 32'd1, "R7 mode write");
        push(1, 0, p, 'hE4 + 4 * p, 32'd1, "R7 reset write");
        push(0, 0, p, 'hE4 + 4 * p, 32'd0, "R7 poll read 1");
        poll_q.push_back(s1);
        if (s1 != 0) begin
            push(0, 0, p, 'hE4 + 4 * p, 32'd0, "R7 poll read 2");
            poll_q.push_back(s2);
        end
        gap_chk = 1;
        start_reset = 1;
        @(posedge clk); #1 start_reset = 0; exp_busy = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 0 && bus_req === 0 && reject === 0, "R8 reset state", {busy, bus_req, reject}, 0);
        rst = 0;
        @(negedge clk);

        lat = 1; kick_ok(0, 0, 0, 0, 0, 32'h1000_0000, 1, 1, 1); wait_done();
        lat = 0; kick_ok(3, 1, 1, 1, 2, 32'hABCD_EF00, 16383, 0, 0); wait_done();
        lat = 2; kick_ok(5, 1, 0, 1, 3, 32'h0000_0100, 700, 1, 1); wait_done();
        lat = 1; kick_ok(1, 0, 1, 0, 3, 32'h8000_0000, 42, 1, 0); wait_done();

        try_bad(0, 0, 0, 32'h1000_0040, 4, 1, 1, 0, "R5 unaligned address");
        try_bad(0, 0, 0, 32'h1000_0000, 0, 1, 1, 0, "R5 zero length");
        try_bad(0, 0, 0, 32'h1000_0000, 16384, 1, 1, 0, "R5 length over max");
        try_bad(6, 0, 0, 32'h1000_0000, 4, 1, 1, 0, "R5 path out of range");
        try_bad(7, 0, 0, 32'h0, 0, 0, 0, 1, "R5 reset path out of range");
        try_bad(0, 0, 0, 32'h1000_0000, 4, 1, 0, 0, "R6 write missing reg flag");
        try_bad(0, 0, 0, 32'h1000_0000, 4, 0, 1, 0, "R6 write missing sel flag");
        try_bad(2, 1, 4, 32'h1000_0000, 4, 1, 1, 0, "R6 read source 4");

        lat = 1; reset_path(2, 32'd0, 32'd0); wait_done();
        lat = 2; reset_path(1, 32'd1, 32'd1); wait_done();
        lat = 0; reset_path(5, 32'd3, 32'd0); wait_done();

        // R9: starts during a sequence are ignored
        lat = 3; kick_ok(4, 0, 0, 0, 0, 32'h2000_0000, 9, 1, 1);
        repeat (2) @(negedge clk);
        set_req(0, 1, 0, 0, 0, 32'h0000_0055, 0, 0, 0);
        start_kick = 1; start_reset = 1;
        @(posedge clk); #1 start_kick = 0; start_reset = 0;
        chk(reject === 1'b0, "R9 start while busy no reject", 64'(reject), 0);
        wait_done();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule